// File: doc/BRIEF.md
# UART Loopback and Modem Status Mirror

This block sits beside the register file of a UART. It carries out the loopback behaviour. While loopback is active, the modem control outputs that software drives are reflected onto the modem status flags. Every write to the control register also produces a replacement value for the modem-status interrupt bits. Transmitted bytes and send-break edges are turned into receive-buffer push requests, and external receive data is dropped. While loopback is inactive, the status flags follow the external modem pins and only external receive data reaches the receive buffer.

Push requests leave the block on two ordered lanes. Lane 0 always holds the older entry. Lane 1 is used only when a transmit byte and a break must both be pushed in the same cycle. Decisions that depend on the loopback state use the state held at the start of the cycle, so a control write takes effect from the next cycle.

Top module: `uart_loop_mirror`

## Requirements
- R1: After reset, loopback is off, no push or interrupt update is signalled, and `ms_flags_o` equals the modem pins.
- R2: In loopback, the flags (bit 3 ring, bit 2 carrier detect, bit 1 clear-to-send, bit 0 data-set-ready) take Out2, Out1, RTS and DTR respectively. They are visible in the cycle after the control write.
- R3: The mirroring is recomputed on every control write that has loopback set. This includes the first write that only sets the enable, and later writes that change only the modem control bits.
- R4: One cycle after a control write with loopback set, `ms_int_upd_o` pulses and `ms_int_val_o` holds the new mirrored flags in the same bit order. All four interrupt bits are replaced: a flag at 0 clears its bit.
- R5: In loopback, a transmit write produces a lane-0 push one cycle later. The entry carries the byte in bits 7:0 and zeros in every other bit.
- R6: In loopback, external receive data produces no push.
- R7: In loopback, a 0-to-1 change of the send-break input produces one push of an entry with only bit 10 set. Holding the input high or lowering it pushes nothing.
- R8: With loopback off, transmit writes, break edges and control writes produce neither pushes nor interrupt updates. External receive bytes are pushed on lane 0 with zeros above bit 7.
- R9: With loopback off, `ms_flags_o` follows the modem pins in the same cycle.
- R10: A transmit write and a break edge in the same loopback cycle push the data on lane 0 and the break on lane 1. Lane 1 is never used without lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| lbe_i | input | 1 | Loopback enable field of the written value |
| out1_i | input | 1 | Out1 field of the written value |
| out2_i | input | 1 | Out2 field of the written value |
| rts_i | input | 1 | RTS field of the written value |
| dtr_i | input | 1 | DTR field of the written value |
| tx_wr_i | input | 1 | Transmit data write strobe |
| tx_data_i | input | 8 | Transmit byte |
| brk_i | input | 1 | Send-break control bit (level) |
| rx_valid_i | input | 1 | External receive byte valid |
| rx_data_i | input | 8 | External receive byte |
| pin_ms_i | input | 4 | External modem pins {ring, carrier, cts, dsr} |
| ms_flags_o | output | 4 | Modem status flags {ring, carrier, cts, dsr} |
| push0_o | output | 1 | Receive push, lane 0 (older) |
| push0_data_o | output | 11 | Lane 0 entry, bit 10 marks break |
| push1_o | output | 1 | Receive push, lane 1 (younger) |
| push1_data_o | output | 11 | Lane 1 entry |
| ms_int_upd_o | output | 1 | Modem-status interrupt bits replacement strobe |
| ms_int_val_o | output | 4 | Replacement interrupt bits {ring, carrier, cts, dsr} |

## Verification
A stale or wrong loopback state bit shows up at once. `ms_flags_o` would follow the pins while it should hold the mirror, or the reverse. The next transmit write or external byte would also push on the wrong path one cycle later. A wrong mirror register, or a wrong cross-mapping, is visible on the flags in the cycle after the control write and on the interrupt value in that same cycle. A break-edge register that is stuck high or low shows up as a missing or repeated break entry in the cycle after the second raise of the break input.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int unsigned MS_N   = 4;
  localparam int unsigned MS_DSR = 0;
  localparam int unsigned MS_CTS = 1;
  localparam int unsigned MS_DCD = 2;
  localparam int unsigned MS_RI  = 3;
endpackage

// File: rtl/ulm_status.sv
module ulm_status
  import uart_lb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctrl_wr_i,
  input  logic            lbe_i,
  input  logic [MS_N-1:0] ctl_i,
  input  logic [MS_N-1:0] pin_i,
  output logic            lbe_o,
  output logic [MS_N-1:0] flags_o,
  output logic            int_upd_o,
  output logic [MS_N-1:0] int_val_o
);
  logic            lbe_q;
  logic [MS_N-1:0] mir_q;
  logic            upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lbe_q <= 1'b0;
      mir_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (ctrl_wr_i) begin
        lbe_q <= lbe_i;
        if (lbe_i) begin
          mir_q <= ctl_i;
          upd_q <= 1'b1;
        end
      end
    end
  end

  assign lbe_o     = lbe_q;
  assign flags_o   = lbe_q ? mir_q : pin_i;
  assign int_upd_o = upd_q;
  assign int_val_o = mir_q;

  // R4
  upd_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_upd_o |-> $past(ctrl_wr_i && lbe_i));
  // R2
  mirror_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lbe_q && $past(lbe_q) && !$past(ctrl_wr_i)) |-> $stable(flags_o));
  // R4
  upd_matches_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_upd_o |-> (int_val_o == flags_o));
endmodule

// File: rtl/ulm_inject.sv
module ulm_inject #(
  parameter int unsigned DW      = 8,
  parameter int unsigned BRK_BIT = 10,
  localparam int unsigned EW     = BRK_BIT + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lbe_i,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          brk_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          push0_o,
  output logic [EW-1:0] push0_data_o,
  output logic          push1_o,
  output logic [EW-1:0] push1_data_o
);
  localparam logic [EW-1:0] BRK_WORD = EW'(1) << BRK_BIT;

  logic brk_q;
  logic brk_rise;
  logic lb_tx, lb_brk, ext_rx;

  assign brk_rise = brk_i & ~brk_q;
  assign lb_tx    = lbe_i & tx_wr_i;
  assign lb_brk   = lbe_i & brk_rise;
  assign ext_rx   = ~lbe_i & rx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q        <= 1'b0;
      push0_o      <= 1'b0;
      push0_data_o <= '0;
      push1_o      <= 1'b0;
      push1_data_o <= '0;
    end else begin
      brk_q        <= brk_i;
      push0_o      <= lb_tx | lb_brk | ext_rx;
      push1_o      <= lb_tx & lb_brk;
      push1_data_o <= BRK_WORD;
      if (lb_tx)       push0_data_o <= EW'(tx_data_i);
      else if (lb_brk) push0_data_o <= BRK_WORD;
      else             push0_data_o <= EW'(rx_data_i);
    end
  end

  // R10
  lane_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push1_o |-> (push0_o && !push0_data_o[BRK_BIT] && push1_data_o[BRK_BIT]));
  // R6
  no_ext_in_lb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push0_o && $past(lbe_i)) |-> $past(tx_wr_i || brk_rise));
  // R7
  brk_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push0_o && push0_data_o[BRK_BIT]) |-> $past(brk_i && !brk_q));
endmodule

// File: rtl/uart_loop_mirror.sv
module uart_loop_mirror
  import uart_lb_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned BRK_BIT = 10,
  localparam int unsigned EW     = BRK_BIT + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctrl_wr_i,
  input  logic            lbe_i,
  input  logic            out1_i,
  input  logic            out2_i,
  input  logic            rts_i,
  input  logic            dtr_i,
  input  logic            tx_wr_i,
  input  logic [DW-1:0]   tx_data_i,
  input  logic            brk_i,
  input  logic            rx_valid_i,
  input  logic [DW-1:0]   rx_data_i,
  input  logic [MS_N-1:0] pin_ms_i,
  output logic [MS_N-1:0] ms_flags_o,
  output logic            push0_o,
  output logic [EW-1:0]   push0_data_o,
  output logic            push1_o,
  output logic [EW-1:0]   push1_data_o,
  output logic            ms_int_upd_o,
  output logic [MS_N-1:0] ms_int_val_o
);
  logic [MS_N-1:0] ctl;
  logic            lbe_q;

  // cross-mapping of modem controls onto status positions
  always_comb begin
    ctl         = '0;
    ctl[MS_RI]  = out2_i;
    ctl[MS_DCD] = out1_i;
    ctl[MS_CTS] = rts_i;
    ctl[MS_DSR] = dtr_i;
  end

  ulm_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (ctrl_wr_i),
    .lbe_i     (lbe_i),
    .ctl_i     (ctl),
    .pin_i     (pin_ms_i),
    .lbe_o     (lbe_q),
    .flags_o   (ms_flags_o),
    .int_upd_o (ms_int_upd_o),
    .int_val_o (ms_int_val_o)
  );

  ulm_inject #(.DW(DW), .BRK_BIT(BRK_BIT)) u_inject (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lbe_i        (lbe_q),
    .tx_wr_i      (tx_wr_i),
    .tx_data_i    (tx_data_i),
    .brk_i        (brk_i),
    .rx_valid_i   (rx_valid_i),
    .rx_data_i    (rx_data_i),
    .push0_o      (push0_o),
    .push0_data_o (push0_data_o),
    .push1_o      (push1_o),
    .push1_data_o (push1_data_o)
  );
endmodule

// File: tb/sim_uart_loop_mirror.sv
module sim_uart_loop_mirror;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ctrl_wr = 0, lbe = 0, out1 = 0, out2 = 0, rts = 0, dtr = 0;
  logic tx_wr = 0, brk = 0, rx_valid = 0;
  logic [7:0] tx_data = 0, rx_data = 0;
  logic [3:0] pins = 0;
  logic [3:0] flags, int_val;
  logic p0, p1, upd;
  logic [10:0] d0, d1;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit m_lbe = 0, m_brk = 0;
  bit [3:0] m_mir = 0;
  bit e_p0 = 0, e_p1 = 0, e_upd = 0;
  int e_d0 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_loop_mirror u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_wr_i(ctrl_wr), .lbe_i(lbe),
    .out1_i(out1), .out2_i(out2), .rts_i(rts), .dtr_i(dtr),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .brk_i(brk),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .pin_ms_i(pins),
    .ms_flags_o(flags), .push0_o(p0), .push0_data_o(d0),
    .push1_o(p1), .push1_data_o(d1),
    .ms_int_upd_o(upd), .ms_int_val_o(int_val));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    bit [3:0] ef;
    ef = m_lbe ? m_mir : pins;
    chk({req, " flags"}, flags, ef);
    chk({req, " push0"}, p0, e_p0);
    if (e_p0) chk({req, " data0"}, d0, e_d0);
    chk({req, " push1"}, p1, e_p1);
    if (e_p1) chk({req, " data1"}, d1, 11'h400);
    chk({req, " upd"}, upd, e_upd);
    if (e_upd) chk({req, " intval"}, int_val, m_mir);
  endtask

  // apply inputs for one cycle, advance model, check after the edge
  task automatic step(string req);
    bit rise;
    @(posedge clk);
    rise  = brk && !m_brk;
    e_p0  = (m_lbe && (tx_wr || rise)) || (!m_lbe && rx_valid);
    e_p1  = m_lbe && tx_wr && rise;
    e_d0  = (m_lbe && tx_wr) ? int'(tx_data) : (m_lbe && rise) ? 'h400 : int'(rx_data);
    e_upd = ctrl_wr && lbe;
    m_brk = brk;
    if (ctrl_wr) begin
      m_lbe = lbe;
      if (lbe) m_mir = {out2, out1, rts, dtr};
    end
    @(negedge clk);
    compare(req);
    ctrl_wr = 0; tx_wr = 0; rx_valid = 0;
  endtask

  task automatic wctl(bit l, bit o2, bit o1, bit r, bit d);
    ctrl_wr = 1; lbe = l; out2 = o2; out1 = o1; rts = r; dtr = d;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    pins = 4'b1010;
    repeat (2) @(negedge clk);
    // R1 reset state
    compare("R1");
    rst_ni = 1;
    @(negedge clk);
    compare("R1");
    // R9 pins pass through with loopback off
    pins = 4'b0101; #1; compare("R9");
    pins = 4'b1100; step("R9");
    // R8 loopback off: tx, break and ctrl writes do nothing; ext rx pushed
    tx_wr = 1; tx_data = 8'h5a; step("R8");
    brk = 1; step("R8");
    brk = 0; step("R8");
    wctl(0, 1, 1, 1, 1); step("R8");
    rx_valid = 1; rx_data = 8'hc3; step("R8");
    // R3 write that only sets enable mirrors current controls (all zero)
    wctl(1, 0, 0, 0, 0); step("R3");
    step("R3");
    // R2 cross-mapping, one control at a time
    wctl(1, 1, 0, 0, 0); step("R2 out2->ri");
    wctl(1, 0, 1, 0, 0); step("R2 out1->dcd");
    wctl(1, 0, 0, 1, 0); step("R2 rts->cts");
    wctl(1, 0, 0, 0, 1); step("R2 dtr->dsr");
    // R4 full set then all cleared
    wctl(1, 1, 1, 1, 1); step("R4");
    pins = 4'b0000; step("R4 hold");
    wctl(1, 0, 0, 0, 0); step("R4 clear");
    // R6 ext rx discarded
    rx_valid = 1; rx_data = 8'h77; step("R6");
    // R5 tx loopback
    tx_wr = 1; tx_data = 8'hff; step("R5");
    tx_wr = 1; tx_data = 8'h01; rx_valid = 1; rx_data = 8'h99; step("R5");
    // R7 break edge once only
    brk = 1; step("R7 rise");
    step("R7 hold");
    brk = 0; step("R7 fall");
    // R10 tx + break same cycle
    brk = 1; tx_wr = 1; tx_data = 8'h3c; step("R10");
    brk = 0; step("R10");
    // R3 modem-only rewrite while already in loopback
    wctl(1, 1, 0, 1, 0); step("R3");
    // leave loopback, back to pins
    wctl(0, 0, 0, 0, 0); pins = 4'b0110; step("R8 exit");
    tx_wr = 1; tx_data = 8'h42; step("R8");
    // R9 pin change after exit
    pins = 4'b1001; #1; compare("R9");
    step("R9");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule